// File: doc/BRIEF.md
# 8-bit Timer with Compare Toggle and Input Capture

This block is an 8-bit timer/event counter. An up-counter advances on ticks taken either from an internal free-running prescaler (seven power-of-two divide ratios) or from rising edges seen on an external event pin. In timer mode the counter is compared against a programmed match value. On a match it returns to zero, emits a one-cycle interrupt pulse and inverts the compare output pin, so the pin carries a square wave with a 50% duty cycle.

In capture mode no match is evaluated. A chosen transition on the capture pin (falling, rising or either) stores the running count in the capture register, clears the counter so it restarts, and pulses the interrupt. The interval between two capture events can then be read directly. The counter wraps freely from 255 to 0 in this mode.

A start strobe clears the counter, the prescaler and the compare output. A separate run enable freezes counting without losing the count. Both external pins pass through two synchronizer flops before edge detection.

Top module: `timer_capcmp`

## Requirements
- R1: After reset, count, cap_val, irq and cmp_out are all 0.
- R2: clk_sel picks the tick source: 0 divides the clock by 2, 1 by 4, 2 by 8, 3 by 32, 4 by 128, 5 by 512, 6 by 2048, and 7 selects rising edges of ext_clk.
- R3: In timer mode (cap_mode=0), when a tick arrives while count equals cmp_val N, the count returns to 0 and irq is high for one cycle. Matches therefore repeat every N+1 ticks.
- R4: cmp_out inverts on every match, so its level differs between consecutive interrupt pulses.
- R5: With clk_sel=7, each rising edge of ext_clk advances the count by one. Falling edges do not advance it.
- R6: A cycle with start=1 leaves count=0 and cmp_out=0 on the next cycle, and restarts the prescaler.
- R7: While run_en=0, count holds its value and no capture occurs. Counting resumes from that value when run_en returns to 1.
- R8: In capture mode (cap_mode=1), a qualifying cap_in edge copies count into cap_val, clears count and pulses irq.
- R9: edge_sel chooses the qualifying capture edge: 0 selects falling, 1 selects rising, and 2 or 3 selects both.
- R10: In capture mode, count wraps from 255 to 0 and keeps counting, and no interrupt is raised without a capture edge, whatever cmp_val holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clears counter, prescaler and compare output |
| run_en | input | 1 | Count enable; 0 freezes the counter |
| cap_mode | input | 1 | 0 timer/compare mode, 1 capture mode |
| clk_sel | input | 3 | Tick source select |
| edge_sel | input | 2 | Capture edge select |
| cmp_val | input | 8 | Match value |
| ext_clk | input | 1 | External event clock pin |
| cap_in | input | 1 | Capture trigger pin |
| count | output | 8 | Running count |
| cap_val | output | 8 | Last captured count |
| irq | output | 1 | One-cycle interrupt pulse |
| cmp_out | output | 1 | Compare toggle output |

## Verification
A corrupted count or a wrong prescaler phase shows up at the ports as a shifted interrupt period. It becomes visible within one match period, which is at most (N+1) times the divide ratio. A compare flop stuck at one level shows within two interrupt pulses, because cmp_out must differ between them. A bad capture path shows up in the first capture: cap_val no longer equals the count that was visible on the cycle before irq, or count does not restart near zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    CS_DIV2 = 3'd0, CS_DIV4 = 3'd1, CS_DIV8 = 3'd2, CS_DIV32 = 3'd3,
    CS_DIV128 = 3'd4, CS_DIV512 = 3'd5, CS_DIV2048 = 3'd6, CS_EXT = 3'd7
  } clk_sel_e;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'd0, EDGE_RISE = 2'd1, EDGE_ANY = 2'd2, EDGE_ANY2 = 2'd3
  } edge_sel_e;

  // number of prescaler bits that must all be ones to produce a tick
  function automatic int div_shift(logic [2:0] sel);
    case (sel)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 3;
      3'd3: return 5;
      3'd4: return 7;
      3'd5: return 9;
      default: return 11;
    endcase
  endfunction

  function automatic logic edge_hit(logic [1:0] es, logic rise, logic fall);
    case (es)
      2'd0: return fall;
      2'd1: return rise;
      default: return rise | fall;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PRE_W; i++) mask[i] = (i < tmr_pkg::div_shift(sel));
  end

  assign tick = &(pre | ~mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre <= '0;
    else if (clr) pre <= '0;
    else          pre <= pre + 1'b1;
  end
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         run_en,
  input  logic         cap_mode,
  input  logic         tick,
  input  logic         cap_hit,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] count,
  output logic [W-1:0] cap_val,
  output logic         irq,
  output logic         cmp_out,
  output logic         match_evt,
  output logic         cap_evt
);
  assign match_evt = !start && !cap_mode && run_en && tick && (count == cmp_val);
  assign cap_evt   = !start && cap_mode && run_en && cap_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      cap_val <= '0;
      irq     <= 1'b0;
      cmp_out <= 1'b0;
    end else begin
      irq <= match_evt | cap_evt;
      if (start) begin
        count   <= '0;
        cmp_out <= 1'b0;
      end else if (cap_evt) begin
        cap_val <= count;
        count   <= '0;
      end else if (match_evt) begin
        count   <= '0;
        cmp_out <= ~cmp_out;
      end else if (run_en && tick) begin
        count <= count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/timer_capcmp.sv
module timer_capcmp #(
  parameter int W     = 8,
  parameter int PRE_W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         run_en,
  input  logic         cap_mode,
  input  logic [2:0]   clk_sel,
  input  logic [1:0]   edge_sel,
  input  logic [W-1:0] cmp_val,
  input  logic         ext_clk,
  input  logic         cap_in,
  output logic [W-1:0] count,
  output logic [W-1:0] cap_val,
  output logic         irq,
  output logic         cmp_out
);
  logic pre_tick, ext_rise, ext_fall, cap_rise, cap_fall;
  logic tick, cap_hit, match_evt, cap_evt;

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(start), .sel(clk_sel), .tick(pre_tick)
  );

  tmr_edge_sync #(.STAGES(2)) u_ext (
    .clk(clk), .rst_n(rst_n), .pin(ext_clk), .rise(ext_rise), .fall(ext_fall)
  );

  tmr_edge_sync #(.STAGES(2)) u_cap (
    .clk(clk), .rst_n(rst_n), .pin(cap_in), .rise(cap_rise), .fall(cap_fall)
  );

  assign tick    = (clk_sel == tmr_pkg::CS_EXT) ? ext_rise : pre_tick;
  assign cap_hit = tmr_pkg::edge_hit(edge_sel, cap_rise, cap_fall);

  tmr_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .start(start), .run_en(run_en),
    .cap_mode(cap_mode), .tick(tick), .cap_hit(cap_hit), .cmp_val(cmp_val),
    .count(count), .cap_val(cap_val), .irq(irq), .cmp_out(cmp_out),
    .match_evt(match_evt), .cap_evt(cap_evt)
  );

  logic unused_ext_fall;
  assign unused_ext_fall = ext_fall;
endmodule

// File: rtl/timer_capcmp_chk.sv
module timer_capcmp_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         run_en,
  input logic         cap_mode,
  input logic [W-1:0] count,
  input logic [W-1:0] cap_val,
  input logic         irq,
  input logic         cmp_out,
  input logic         match_evt,
  input logic         cap_evt
);
  p_match_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> (count == '0 && irq));

  p_cmp_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> (cmp_out != $past(cmp_out)));

  p_start_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (count == '0 && !cmp_out && !irq));

  p_pause_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !start) |=> $stable(count));

  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_val == $past(count) && count == '0 && irq));

  p_no_match_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode && !cap_evt) |=> !irq);
endmodule

bind timer_capcmp timer_capcmp_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .run_en(run_en),
  .cap_mode(cap_mode), .count(count), .cap_val(cap_val), .irq(irq),
  .cmp_out(cmp_out), .match_evt(match_evt), .cap_evt(cap_evt)
);

// File: tb/timer_capcmp_tb.sv
`timescale 1ns/1ps
module timer_capcmp_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, run_en = 1'b0, cap_mode = 1'b0;
  logic [2:0] clk_sel = 3'd0;
  logic [1:0] edge_sel = 2'd1;
  logic [7:0] cmp_val = 8'd0;
  logic       ext_clk = 1'b0, cap_in = 1'b0;
  logic [7:0] count, cap_val;
  logic       irq, cmp_out;

  int tests = 0, fails = 0;
  int cyc = 0, irq_seen = 0;
  int prev_cnt = 0, exp_cap = 0;
  bit wrap_seen = 0;

  timer_capcmp u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .run_en(run_en),
    .cap_mode(cap_mode), .clk_sel(clk_sel), .edge_sel(edge_sel),
    .cmp_val(cmp_val), .ext_clk(ext_clk), .cap_in(cap_in),
    .count(count), .cap_val(cap_val), .irq(irq), .cmp_out(cmp_out)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  // observer: value before the edge that raised irq is the expected capture
  always @(negedge clk) begin
    if (irq) begin
      irq_seen++;
      exp_cap = prev_cnt;
    end
    if (prev_cnt == 255 && count == 8'd0) wrap_seen = 1;
    prev_cnt = int'(count);
  end

  typedef struct packed {
    logic [2:0]  sel;
    logic [7:0]  n;
    logic [15:0] per;
  } vec_t;
  // R2/R3: period = divide ratio * (N+1)
  localparam vec_t VEC [5] = '{
    '{3'd0, 8'd4, 16'd10},
    '{3'd1, 8'd3, 16'd16},
    '{3'd3, 8'd1, 16'd64},
    '{3'd2, 8'd0, 16'd8},
    '{3'd4, 8'd2, 16'd384}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #0.5;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    #0.5;
  endtask

  task automatic wait_irq();
    int base;
    base = irq_seen;
    for (int i = 0; i < 5000 && irq_seen == base; i++) @(negedge clk);
    #0.5;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    cycles(4);
    // R1 reset state
    chk(count == 0 && cap_val == 0 && !irq && !cmp_out, "R1", int'(count), 0);
    rst_n = 1'b1;
    cycles(2);
    chk(count == 0 && !irq, "R1", int'(count), 0);

    // table walk: R2 divide ratio, R3 period, R4 toggle
    run_en = 1'b1;
    foreach (VEC[k]) begin
      int t1, t2;
      logic c1;
      clk_sel = VEC[k].sel;
      cmp_val = VEC[k].n;
      pulse_start();
      wait_irq(); t1 = cyc; c1 = cmp_out;
      chk(count == 0, "R3", int'(count), 0);
      wait_irq(); t2 = cyc;
      chk(t2 - t1 == int'(VEC[k].per), "R2", t2 - t1, int'(VEC[k].per));
      chk(cmp_out != c1, "R4", int'(cmp_out), int'(!c1));
    end

    // R7 pause keeps count, R6 start clears
    clk_sel = 3'd0; cmp_val = 8'd200;
    pulse_start();
    cycles(20);
    run_en = 1'b0;
    cycles(2);
    begin
      int held;
      held = int'(count);
      cycles(20);
      chk(int'(count) == held, "R7", int'(count), held);
      run_en = 1'b1;
      cycles(10);
      chk(int'(count) > held, "R7", int'(count), held + 1);
    end
    pulse_start();
    chk(count == 0 && !cmp_out, "R6", int'(count), 0);

    // R5 external event clock, N=2
    clk_sel = 3'd7; cmp_val = 8'd2;
    pulse_start();
    for (int e = 1; e <= 3; e++) begin
      int base;
      base = irq_seen;
      @(negedge clk); ext_clk = 1'b1;
      cycles(5);
      chk(int'(count) == e % 3, "R5", int'(count), e % 3);
      @(negedge clk); ext_clk = 1'b0;
      cycles(5);
      chk(int'(count) == e % 3, "R5", int'(count), e % 3);
      if (e == 3) chk(irq_seen == base + 1, "R3", irq_seen - base, 1);
    end

    // R8 capture, R9 edge selection
    cap_mode = 1'b1; clk_sel = 3'd0; edge_sel = 2'd1; cmp_val = 8'd5;
    pulse_start();
    cycles(37);
    begin
      int base;
      base = irq_seen;
      @(negedge clk); cap_in = 1'b1;
      cycles(6);
      chk(irq_seen == base + 1, "R8", irq_seen - base, 1);
      chk(int'(cap_val) == exp_cap, "R8", int'(cap_val), exp_cap);
      chk(exp_cap > 5, "R10", exp_cap, 6);
      chk(count <= 3, "R8", int'(count), 3);
      base = irq_seen;
      @(negedge clk); cap_in = 1'b0;
      cycles(6);
      chk(irq_seen == base, "R9", irq_seen - base, 0);
      edge_sel = 2'd0;
      @(negedge clk); cap_in = 1'b1;
      cycles(6);
      chk(irq_seen == base, "R9", irq_seen - base, 0);
      @(negedge clk); cap_in = 1'b0;
      cycles(6);
      chk(irq_seen == base + 1, "R9", irq_seen - base, 1);
      chk(int'(cap_val) == exp_cap, "R8", int'(cap_val), exp_cap);
      base = irq_seen;
      edge_sel = 2'd2;
      @(negedge clk); cap_in = 1'b1;
      cycles(6);
      @(negedge clk); cap_in = 1'b0;
      cycles(6);
      chk(irq_seen == base + 2, "R9", irq_seen - base, 2);
      // R7: no capture while paused
      run_en = 1'b0;
      base = irq_seen;
      @(negedge clk); cap_in = 1'b1;
      cycles(6);
      chk(irq_seen == base, "R7", irq_seen - base, 0);
      run_en = 1'b1;
      @(negedge clk); cap_in = 1'b0;
      cycles(6);

      // R10 wrap without match interrupt
      pulse_start();
      base = irq_seen;
      wrap_seen = 0;
      cycles(600);
      chk(irq_seen == base, "R10", irq_seen - base, 0);
      chk(wrap_seen, "R10", int'(wrap_seen), 1);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule